// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block does the data merging for partial-word left and right accesses. A pair of these accesses reads or writes a word whose address is not a multiple of the word size. Each request names one of four operations: load toward the high end, load toward the low end, store toward the high end, and store toward the low end. With the request come a byte address, the aligned memory word at that address, and the current register value. The low address bits select how far the memory word is shifted, in whole bytes. The bytes that lie outside the accessed span keep their old contents.

For loads the block returns the merged register value. For stores it returns the merged memory word and a byte-enable mask that marks only the bytes the register data replaced. It also gives the word-aligned address at which the memory word is read or written. Byte lane 0 is the least significant byte, and that lane order is fixed. A parameter selects whether the result leaves the block in the same cycle or one clock later from an output register.

Top module: `uam_merge`

## Requirements
- R1: The response address equals the request address with its low log2(NBYTES) bits forced to zero.
- R2: Load-left (op code 0) with offset o and k = NBYTES-1-o returns, in byte lane i, memory lane i-k when i >= k and register lane i otherwise.
- R3: Load-right (op code 1) with offset o returns, in byte lane i, memory lane i+o when i+o < NBYTES and register lane i otherwise.
- R4: Store-left (op code 2) with offset o and k = NBYTES-1-o writes register lane i+k into memory lane i for i <= o and keeps the other memory lanes. Byte-enable bit i is set exactly for i <= o.
- R5: Store-right (op code 3) with offset o writes register lane i-o into memory lane i for i >= o and keeps memory lanes below o. Byte-enable bit i is set exactly for i >= o.
- R6: Load-left at offset NBYTES-1 and load-right at offset 0 return the whole memory word. Store-left at offset NBYTES-1 and store-right at offset 0 return the whole register with all byte enables set.
- R7: Load-right at an unaligned address A, followed by load-left at A+NBYTES-1 on the next word, assembles bytes A through A+NBYTES-1 little-endian. The matching store pair writes exactly those bytes.
- R8: Loads leave the store side inert: byte enables are zero and the store word equals the memory input. Stores leave the register output equal to the register input.
- R9: With REG_OUT=1 every output, including the valid flag, appears one clock after its request, and all outputs are zero after a synchronous reset. With REG_OUT=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid |
| req_op | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| req_addr | input | AW | Byte address of the access |
| req_mem | input | 8*NBYTES | Aligned memory word at the access address |
| req_reg | input | 8*NBYTES | Current register value |
| rsp_vld | output | 1 | Response valid |
| rsp_addr | output | AW | Word-aligned memory address |
| rsp_ld_data | output | 8*NBYTES | Merged register value |
| rsp_st_data | output | 8*NBYTES | Merged memory word |
| rsp_st_be | output | NBYTES | Byte enables for the store |

## Verification
The bench builds two instances with NBYTES=4 and AW=16: one with REG_OUT=1 and one with REG_OUT=0. Both receive the same stimulus. The registered copy brings reset values and the one-cycle latency of data and valid within reach. The combinational copy shows that results appear in the same cycle. With four byte lanes, every offset of every operation can be swept, including both full-word corners and the split left/right pairs at each unaligned offset.

// File: rtl/uam_pkg.sv
package uam_pkg;

    typedef enum logic [1:0] {
        OP_LOAD_L  = 2'd0,
        OP_LOAD_R  = 2'd1,
        OP_STORE_L = 2'd2,
        OP_STORE_R = 2'd3
    } uam_op_e;

    function automatic logic op_is_store(input uam_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_left(input uam_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/uam_load_merge.sv
module uam_load_merge #(
    parameter int NBYTES = 4,
    localparam int DW = 8 * NBYTES,
    localparam int OW = $clog2(NBYTES)
) (
    input  logic          left,
    input  logic [OW-1:0] off,
    input  logic [DW-1:0] mem,
    input  logic [DW-1:0] regv,
    output logic [DW-1:0] merged
);
    localparam logic [DW-1:0] ALL = {DW{1'b1}};

    logic [OW+2:0] sh;

    // left: shift by (NBYTES-1-off) bytes; right: shift by off bytes
    assign sh = {(left ? ~off : off), 3'b000};

    always_comb begin
        if (left) begin
            merged = (mem << sh) | (regv & ~(ALL << sh));
        end else begin
            merged = (mem >> sh) | (regv & ~(ALL >> sh));
        end
    end
endmodule

// File: rtl/uam_store_merge.sv
module uam_store_merge #(
    parameter int NBYTES = 4,
    localparam int DW = 8 * NBYTES,
    localparam int OW = $clog2(NBYTES)
) (
    input  logic              left,
    input  logic [OW-1:0]     off,
    input  logic [DW-1:0]     mem,
    input  logic [DW-1:0]     regv,
    output logic [DW-1:0]     merged,
    output logic [NBYTES-1:0] be
);
    localparam logic [DW-1:0] ALL = {DW{1'b1}};

    logic [OW+2:0] sh;

    assign sh = {(left ? ~off : off), 3'b000};

    always_comb begin
        if (left) begin
            merged = (mem & ~(ALL >> sh)) | (regv >> sh);
        end else begin
            merged = (regv << sh) | (mem & ~(ALL << sh));
        end
    end

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane_en
        assign be[gi] = left ? (OW'(gi) <= off) : (OW'(gi) >= off);
    end
endmodule

// File: rtl/uam_out_stage.sv
module uam_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         d_vld,
    input  logic [W-1:0] d,
    output logic         q_vld,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q_vld <= 1'b0;
                q     <= '0;
            end else begin
                q_vld <= d_vld;
                q     <= d;
            end
        end
    end else begin : g_comb
        logic unused_ctl;
        assign unused_ctl = clk ^ rst;
        assign q_vld      = d_vld;
        assign q          = d;
    end
endmodule

// File: rtl/uam_merge.sv
module uam_merge
    import uam_pkg::*;
#(
    parameter int NBYTES  = 4,
    parameter int AW      = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int DW = 8 * NBYTES,
    localparam int OW = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_mem,
    input  logic [DW-1:0]     req_reg,
    output logic              rsp_vld,
    output logic [AW-1:0]     rsp_addr,
    output logic [DW-1:0]     rsp_ld_data,
    output logic [DW-1:0]     rsp_st_data,
    output logic [NBYTES-1:0] rsp_st_be
);
    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [DW-1:0]     ld;
        logic [DW-1:0]     st;
        logic [NBYTES-1:0] be;
    } uam_rsp_t;

    localparam int RW = $bits(uam_rsp_t);

    uam_op_e           op;
    logic [OW-1:0]     off;
    logic [DW-1:0]     ld_merged;
    logic [DW-1:0]     st_merged;
    logic [NBYTES-1:0] st_be;
    uam_rsp_t          nxt;
    uam_rsp_t          cur;
    logic [RW-1:0]     cur_flat;

    assign op  = uam_op_e'(req_op);
    assign off = req_addr[OW-1:0];

    uam_load_merge #(.NBYTES(NBYTES)) u_ld (
        .left   (op_is_left(op)),
        .off    (off),
        .mem    (req_mem),
        .regv   (req_reg),
        .merged (ld_merged)
    );

    uam_store_merge #(.NBYTES(NBYTES)) u_st (
        .left   (op_is_left(op)),
        .off    (off),
        .mem    (req_mem),
        .regv   (req_reg),
        .merged (st_merged),
        .be     (st_be)
    );

    always_comb begin
        nxt.addr = {req_addr[AW-1:OW], {OW{1'b0}}};
        if (op_is_store(op)) begin
            nxt.ld = req_reg;
            nxt.st = st_merged;
            nxt.be = st_be;
        end else begin
            nxt.ld = ld_merged;
            nxt.st = req_mem;
            nxt.be = '0;
        end
    end

    uam_out_stage #(.W(RW), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst   (rst),
        .d_vld (req_vld),
        .d     (nxt),
        .q_vld (rsp_vld),
        .q     (cur_flat)
    );

    assign cur         = uam_rsp_t'(cur_flat);
    assign rsp_addr    = cur.addr;
    assign rsp_ld_data = cur.ld;
    assign rsp_st_data = cur.st;
    assign rsp_st_be   = cur.be;
endmodule

// File: rtl/uam_merge_chk.sv
module uam_merge_chk #(
    parameter int NBYTES  = 4,
    parameter int AW      = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int DW = 8 * NBYTES,
    localparam int OW = $clog2(NBYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_vld,
    input logic [1:0]        req_op,
    input logic [AW-1:0]     req_addr,
    input logic [DW-1:0]     req_mem,
    input logic [DW-1:0]     req_reg,
    input logic              rsp_vld,
    input logic [AW-1:0]     rsp_addr,
    input logic [DW-1:0]     rsp_ld_data,
    input logic [DW-1:0]     rsp_st_data,
    input logic [NBYTES-1:0] rsp_st_be
);
    logic              s_vld;
    logic [1:0]        s_op;
    logic [AW-1:0]     s_addr;
    logic [DW-1:0]     s_mem;
    logic [DW-1:0]     s_reg;

    if (REG_OUT) begin : g_seen_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                s_vld  <= 1'b0;
                s_op   <= '0;
                s_addr <= '0;
                s_mem  <= '0;
                s_reg  <= '0;
            end else begin
                s_vld  <= req_vld;
                s_op   <= req_op;
                s_addr <= req_addr;
                s_mem  <= req_mem;
                s_reg  <= req_reg;
            end
        end
    end else begin : g_seen_comb
        assign s_vld  = req_vld;
        assign s_op   = req_op;
        assign s_addr = req_addr;
        assign s_mem  = req_mem;
        assign s_reg  = req_reg;
    end

    logic [OW-1:0] s_off;
    assign s_off = s_addr[OW-1:0];

    p_vld_follow_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_vld == s_vld);

    p_addr_align_r1: assert property (@(posedge clk) disable iff (rst)
        s_vld |-> (rsp_addr[OW-1:0] == '0 && rsp_addr[AW-1:OW] == s_addr[AW-1:OW]));

    p_load_inert_r8: assert property (@(posedge clk) disable iff (rst)
        (s_vld && !s_op[1]) |-> (rsp_st_be == '0 && rsp_st_data == s_mem));

    p_store_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (s_vld && s_op[1]) |-> (rsp_ld_data == s_reg));

    p_be_left_r4: assert property (@(posedge clk) disable iff (rst)
        (s_vld && s_op == 2'd2) |->
            (rsp_st_be[0] && $countones(rsp_st_be) == int'(s_off) + 1));

    p_be_right_r5: assert property (@(posedge clk) disable iff (rst)
        (s_vld && s_op == 2'd3) |->
            (rsp_st_be[NBYTES-1] && $countones(rsp_st_be) == NBYTES - int'(s_off)));

    p_full_load_r6: assert property (@(posedge clk) disable iff (rst)
        (s_vld && ((s_op == 2'd0 && s_off == {OW{1'b1}}) ||
                   (s_op == 2'd1 && s_off == '0))) |-> (rsp_ld_data == s_mem));

    p_full_store_r6: assert property (@(posedge clk) disable iff (rst)
        (s_vld && ((s_op == 2'd2 && s_off == {OW{1'b1}}) ||
                   (s_op == 2'd3 && s_off == '0))) |->
            (rsp_st_data == s_reg && rsp_st_be == {NBYTES{1'b1}}));
endmodule

bind uam_merge uam_merge_chk #(
    .NBYTES  (NBYTES),
    .AW      (AW),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_vld     (req_vld),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_mem     (req_mem),
    .req_reg     (req_reg),
    .rsp_vld     (rsp_vld),
    .rsp_addr    (rsp_addr),
    .rsp_ld_data (rsp_ld_data),
    .rsp_st_data (rsp_st_data),
    .rsp_st_be   (rsp_st_be)
);

// File: tb/tb_uam_merge.sv
module tb_uam_merge;
    localparam int NB = 4;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [1:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_mem = '0;
    logic [31:0] req_reg = '0;

    logic        r_vld, c_vld;
    logic [15:0] r_addr, c_addr;
    logic [31:0] r_ld, c_ld, r_st, c_st;
    logic [3:0]  r_be, c_be;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    uam_merge #(.NBYTES(NB), .AW(AW), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_op(req_op),
        .req_addr(req_addr), .req_mem(req_mem), .req_reg(req_reg),
        .rsp_vld(r_vld), .rsp_addr(r_addr), .rsp_ld_data(r_ld),
        .rsp_st_data(r_st), .rsp_st_be(r_be)
    );

    uam_merge #(.NBYTES(NB), .AW(AW), .REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_op(req_op),
        .req_addr(req_addr), .req_mem(req_mem), .req_reg(req_reg),
        .rsp_vld(c_vld), .rsp_addr(c_addr), .rsp_ld_data(c_ld),
        .rsp_st_data(c_st), .rsp_st_be(c_be)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference model written byte by byte from the requirements
    function automatic logic [31:0] ref_ld(input logic [1:0] op, input int o,
                                           input logic [31:0] m, input logic [31:0] r);
        logic [31:0] v;
        int k;
        k = 3 - o;
        for (int i = 0; i < 4; i++) begin
            if (op == 2'd0)      v[i*8 +: 8] = (i >= k) ? m[(i-k)*8 +: 8] : r[i*8 +: 8];
            else if (op == 2'd1) v[i*8 +: 8] = (i + o < 4) ? m[(i+o)*8 +: 8] : r[i*8 +: 8];
            else                 v[i*8 +: 8] = r[i*8 +: 8];
        end
        return v;
    endfunction

    function automatic logic [31:0] ref_st(input logic [1:0] op, input int o,
                                           input logic [31:0] m, input logic [31:0] r);
        logic [31:0] v;
        int k;
        k = 3 - o;
        for (int i = 0; i < 4; i++) begin
            if (op == 2'd2)      v[i*8 +: 8] = (i <= o) ? r[(i+k)*8 +: 8] : m[i*8 +: 8];
            else if (op == 2'd3) v[i*8 +: 8] = (i >= o) ? r[(i-o)*8 +: 8] : m[i*8 +: 8];
            else                 v[i*8 +: 8] = m[i*8 +: 8];
        end
        return v;
    endfunction

    function automatic logic [3:0] ref_be(input logic [1:0] op, input int o);
        logic [3:0] v;
        for (int i = 0; i < 4; i++) begin
            if (op == 2'd2)      v[i] = (i <= o);
            else if (op == 2'd3) v[i] = (i >= o);
            else                 v[i] = 1'b0;
        end
        return v;
    endfunction

    // Apply one request, check combinational copy at once, registered copy a clock later
    task automatic apply(input string tag, input logic [1:0] op, input logic [15:0] a,
                         input logic [31:0] m, input logic [31:0] r,
                         output logic [31:0] ld, output logic [31:0] st);
        int o;
        o = int'(a[1:0]);
        @(negedge clk);
        req_vld = 1'b1; req_op = op; req_addr = a; req_mem = m; req_reg = r;
        #1;
        check({tag, " comb ld"}, c_ld, ref_ld(op, o, m, r));
        check({tag, " comb st"}, c_st, ref_st(op, o, m, r));
        check({tag, " comb be"}, 32'(c_be), 32'(ref_be(op, o)));
        check({tag, " comb addr R1"}, 32'(c_addr), 32'({a[15:2], 2'b00}));
        @(posedge clk);
        #1;
        check({tag, " reg vld R9"}, 32'(r_vld), 32'd1);
        check({tag, " reg ld"}, r_ld, ref_ld(op, o, m, r));
        check({tag, " reg st"}, r_st, ref_st(op, o, m, r));
        check({tag, " reg be"}, 32'(r_be), 32'(ref_be(op, o)));
        check({tag, " reg addr R1"}, 32'(r_addr), 32'({a[15:2], 2'b00}));
        ld = r_ld;
        st = r_st;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R9 reset vld", 32'(r_vld), 32'd0);
        check("R9 reset ld", r_ld, 32'd0);
        check("R9 reset st", r_st, 32'd0);
        check("R9 reset be", 32'(r_be), 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_load_left();
        logic [31:0] ld, st;
        for (int o = 0; o < 4; o++)
            apply("R2 load-left", 2'd0, 16'h0200 + 16'(o), 32'hA1B2C3D4, 32'h11223344, ld, st);
    endtask

    task automatic t_load_right();
        logic [31:0] ld, st;
        for (int o = 0; o < 4; o++)
            apply("R3 load-right", 2'd1, 16'h0310 + 16'(o), 32'h5566_7788, 32'hDEADBEEF, ld, st);
    endtask

    task automatic t_store_left();
        logic [31:0] ld, st;
        for (int o = 0; o < 4; o++)
            apply("R4 store-left", 2'd2, 16'h0420 + 16'(o), 32'hCAFEF00D, 32'h0BADC0DE, ld, st);
    endtask

    task automatic t_store_right();
        logic [31:0] ld, st;
        for (int o = 0; o < 4; o++)
            apply("R5 store-right", 2'd3, 16'h0530 + 16'(o), 32'h13579BDF, 32'h2468ACE0, ld, st);
    endtask

    task automatic t_full_word();
        logic [31:0] ld, st;
        apply("R6 ll full", 2'd0, 16'h0603, 32'h89ABCDEF, 32'h01234567, ld, st);
        check("R6 ll full word", ld, 32'h89ABCDEF);
        apply("R6 lr full", 2'd1, 16'h0600, 32'h89ABCDEF, 32'h01234567, ld, st);
        check("R6 lr full word", ld, 32'h89ABCDEF);
        apply("R6 sl full", 2'd2, 16'h0603, 32'h89ABCDEF, 32'h01234567, ld, st);
        check("R6 sl full word", st, 32'h01234567);
        check("R6 sl full be", 32'(r_be), 32'hF);
        apply("R6 sr full", 2'd3, 16'h0600, 32'h89ABCDEF, 32'h01234567, ld, st);
        check("R6 sr full word", st, 32'h01234567);
        check("R6 sr full be", 32'(r_be), 32'hF);
    endtask

    task automatic t_inert();
        logic [31:0] ld, st;
        apply("R8 load inert", 2'd1, 16'h0702, 32'h0F0F0F0F, 32'hF0F0F0F0, ld, st);
        check("R8 load st data", st, 32'h0F0F0F0F);
        check("R8 load be", 32'(r_be), 32'd0);
        apply("R8 store keep", 2'd2, 16'h0701, 32'h0F0F0F0F, 32'hF0F0F0F0, ld, st);
        check("R8 store ld data", ld, 32'hF0F0F0F0);
    endtask

    task automatic t_pairs();
        logic [7:0]  bytes [8];
        logic [31:0] w0, w1, ld, st, expw, r1, nw0, nw1, dat;
        for (int i = 0; i < 8; i++) bytes[i] = 8'h30 + 8'(i * 17);
        w0 = {bytes[3], bytes[2], bytes[1], bytes[0]};
        w1 = {bytes[7], bytes[6], bytes[5], bytes[4]};
        for (int o = 1; o < 4; o++) begin
            expw = {bytes[o+3], bytes[o+2], bytes[o+1], bytes[o]};
            apply("R7 pair lr", 2'd1, 16'h0800 + 16'(o), w0, 32'h5A5A5A5A, r1, st);
            apply("R7 pair ll", 2'd0, 16'h0800 + 16'(o + 3), w1, r1, ld, st);
            check("R7 assembled load", ld, expw);
            dat = 32'hE1E2E3E4;
            apply("R7 pair sr", 2'd3, 16'h0800 + 16'(o), w0, dat, ld, nw0);
            apply("R7 pair sl", 2'd2, 16'h0800 + 16'(o + 3), w1, dat, ld, nw1);
            for (int b = 0; b < 8; b++) begin
                logic [7:0] got, want;
                got  = (b < 4) ? nw0[b*8 +: 8] : nw1[(b-4)*8 +: 8];
                want = (b >= o && b < o + 4) ? dat[(b-o)*8 +: 8] : bytes[b];
                check("R7 stored byte", 32'(got), 32'(want));
            end
        end
    endtask

    task automatic t_valid();
        @(negedge clk);
        req_vld = 1'b0;
        #1;
        check("R9 comb vld low", 32'(c_vld), 32'd0);
        check("R9 reg vld held", 32'(r_vld), 32'd1);
        @(posedge clk);
        #1;
        check("R9 reg vld low", 32'(r_vld), 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load_left();
        t_load_right();
        t_store_left();
        t_store_right();
        t_full_word();
        t_inert();
        t_pairs();
        t_valid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule